// File: doc/BRIEF.md
# Configurable Converter Serial Output Port

This block takes 16-bit conversion results and shifts them out serially, MSB first, on a data line. A frame line marks the bits of each word. A single shift register serves every configuration. In master mode the block makes its own bit clock from the system clock. In slave mode a host supplies the bit clock. In slave mode a daisy-chain input is shifted in behind the word, so several converters can share one data line.

In master mode a read-timing pin chooses when a word may go out. With the pin high, the word goes out while the next conversion is busy. With the pin low, the block waits until the busy flag drops. In the wait-for-idle timing only, a 2-bit divide code slows the bit clock. Other pins invert the bit clock, invert the frame polarity, and choose straight binary or two's-complement coding. A word that arrives during a read is held and sent as the next frame.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdout` is 0, `sync` equals `sync_low` (inactive), and `sclk_out` equals `sclk_inv` (idle).
- R2: With `ext_clk_sel`=0 the block drives 16 active edges per word on `sclk_out`, where an active edge is a 0-to-1 change of `sclk_out ^ sclk_inv`. `sdout` takes the next bit, MSB first, in the same system cycle as each active edge.
- R3: With `ext_clk_sel`=0 and `read_during`=0, no frame starts while `conv_busy`=1. A held word starts once `conv_busy` returns to 0.
- R4: With `ext_clk_sel`=0 and `read_during`=1, a frame runs even while `conv_busy`=1.
- R5: In master mode with `read_during`=0, the bit period is 2^(`div_code`+1) system cycles. In every other mode `div_code` is ignored, and in master mode the period is 2 cycles.
- R6: `sync` is high when active if `sync_low`=0, and low when active if `sync_low`=1.
- R7: `sclk_inv`=1 inverts the sense of the bit clock on `sclk_out` (master) and on `sclk_in` (slave).
- R8: `sync` is active for exactly 16 bit periods, starting at the first active edge. After that, in master mode, `sdout` returns to 0, no further active edge occurs and `sclk_out` stays idle.
- R9: With `bin_fmt`=1 the word is sent unchanged. With `bin_fmt`=0, bit 15 is inverted (two's complement).
- R10: With `ext_clk_sel`=1 each active edge of `sclk_in` (0-to-1 of `sclk_in ^ sclk_inv`) shifts out the next bit. `sdout` updates within three system cycles of that edge.
- R11: With `ext_clk_sel`=1 the level of `sdin` at the k-th active edge of a frame appears on `sdout` at active edge k+16.
- R12: A result that arrives while a frame is in progress is sent, intact, as the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_data | input | 16 | Conversion result |
| res_valid | input | 1 | One-cycle strobe for `res_data` |
| conv_busy | input | 1 | Conversion in progress |
| ext_clk_sel | input | 1 | 0: internal bit clock (master), 1: external bit clock (slave) |
| read_during | input | 1 | Master timing: 1 read while busy, 0 read after busy |
| div_code | input | 2 | Bit clock divide code |
| sclk_inv | input | 1 | Bit clock sense invert |
| sync_low | input | 1 | Frame active-low select |
| bin_fmt | input | 1 | 1 straight binary, 0 two's complement |
| sclk_in | input | 1 | External bit clock |
| sdin | input | 1 | Daisy-chain data input |
| sclk_out | output | 1 | Internal bit clock output |
| sdout | output | 1 | Serial data output |
| sync | output | 1 | Frame output |

## Verification
The assertions assume that the mode pins change only while no frame is in progress. They also assume that the block is reset when it moves from slave to master mode, so that chained data left on `sdout` is not taken for a master-mode violation. The stimulus changes modes only between complete frames and resets before the slave-mode run. It issues at most one new result per frame. In slave mode it holds each level of `sclk_in` for six system cycles, so the synchronizer sees every edge.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int W  = 16,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  res_data,
  input  logic          res_valid,
  input  logic          conv_busy,
  input  logic          ext_clk_sel,
  input  logic          read_during,
  input  logic [DW-1:0] div_code,
  input  logic          sclk_inv,
  input  logic          sync_low,
  input  logic          bin_fmt,
  input  logic          sclk_in,
  input  logic          sdin,
  output logic          sclk_out,
  output logic          sdout,
  output logic          sync
);
  localparam int CW = $clog2(W + 1);
  localparam int HW = (1 << DW) - 1;

  logic [W-1:0]  pend, sr;
  logic          pend_v, armed, running, raw, sync_act;
  logic [HW-1:0] hcnt, hlim;
  logic [CW-1:0] fc;
  logic          s1, s2, s3, d1, d2;
  logic [DW-1:0] dsel;
  logic          tick, act, go, load;
  logic [W-1:0]  coded;

  assign dsel  = (!ext_clk_sel && !read_during) ? div_code : '0;
  assign hlim  = HW'((32'd1 << dsel) - 32'd1);
  assign tick  = running && (hcnt == hlim);
  assign act   = ext_clk_sel ? (s2 && !s3) : (tick && !raw);
  assign go    = armed && !running && !ext_clk_sel && (read_during || !conv_busy);
  assign load  = pend_v && !armed && !running && (fc == '0) && !act;
  assign coded = bin_fmt ? pend : {~pend[W-1], pend[W-2:0]};

  assign sclk_out = raw ^ sclk_inv;
  assign sync     = sync_act ^ sync_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; sr <= '0; pend_v <= 1'b0; armed <= 1'b0;
      running <= 1'b0; raw <= 1'b0; sync_act <= 1'b0; sdout <= 1'b0;
      hcnt <= '0; fc <= '0;
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; d1 <= 1'b0; d2 <= 1'b0;
    end else begin
      s1 <= sclk_in ^ sclk_inv; s2 <= s1; s3 <= s2;
      d1 <= sdin; d2 <= d1;

      if (res_valid) begin
        pend   <= res_data;
        pend_v <= 1'b1;
      end else if (load) begin
        pend_v <= 1'b0;
      end

      if (load) begin
        sr    <= coded;
        armed <= 1'b1;
      end

      if (go) begin
        running <= 1'b1;
        hcnt    <= '0;
        raw     <= 1'b0;
      end else if (running) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick && raw) raw <= 1'b0;
      end

      if (act) begin
        if (fc == '0) begin
          sdout <= sr[W-1];
          sr    <= {sr[W-2:0], d2};
          if (armed) begin
            fc       <= CW'(1);
            sync_act <= 1'b1;
            armed    <= 1'b0;
            if (!ext_clk_sel) raw <= 1'b1;
          end
        end else if (fc == CW'(W)) begin
          sync_act <= 1'b0;
          fc       <= '0;
          if (ext_clk_sel) begin
            sdout <= sr[W-1];
            sr    <= {sr[W-2:0], d2};
          end else begin
            sdout   <= 1'b0;
            running <= 1'b0;
          end
        end else begin
          sdout <= sr[W-1];
          sr    <= {sr[W-2:0], d2};
          fc    <= fc + 1'b1;
          if (!ext_clk_sel) raw <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic ext_clk_sel,
  input logic sclk_inv,
  input logic sync_low,
  input logic sclk_out,
  input logic sdout,
  input logic sync
);
  logic ea, ea_prev;
  logic [$clog2(W + 2)-1:0] nrise;

  assign ea = sclk_out ^ sclk_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_prev <= 1'b0;
      nrise   <= '0;
    end else begin
      ea_prev <= ea;
      if (sync == sync_low) nrise <= '0;
      else if (ea && !ea_prev && !ext_clk_sel) nrise <= nrise + 1'b1;
    end
  end

  assert_idle_sclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && sync == sync_low) |-> (sclk_out == sclk_inv));

  assert_idle_sdout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && $past(!ext_clk_sel) && $stable(sync_low) && sync == sync_low) |-> !sdout);

  assert_edge_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && $stable(ext_clk_sel) && $stable(sclk_inv) && $stable(sync_low)
     && sync != sync_low && $changed(sdout)) |-> (ea && !ea_prev));

  assert_frame_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nrise <= ($clog2(W + 2))'(W));
endmodule

bind adc_serial_port adc_serial_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .sclk_inv(sclk_inv),
  .sync_low(sync_low), .sclk_out(sclk_out), .sdout(sdout), .sync(sync)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] res_data = '0;
  logic res_valid = 1'b0, conv_busy = 1'b0, ext_clk_sel = 1'b0, read_during = 1'b0;
  logic [1:0] div_code = '0;
  logic sclk_inv = 1'b0, sync_low = 1'b0, bin_fmt = 1'b1, sclk_in = 1'b0, sdin = 1'b0;
  logic sclk_out, sdout, sync;
  int nchk = 0, nfail = 0;

  adc_serial_port u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] code(input logic [15:0] w, input logic bin);
    return bin ? w : (w ^ 16'h8000);
  endfunction

  function automatic int per(input int d, input logic after);
    return after ? (2 << d) : 2;
  endfunction

  task automatic send(input logic [15:0] w);
    @(negedge clk); res_data = w; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_master(input logic [15:0] expw, input int period, input bit inject,
                            input logic [15:0] injw, input string req);
    int rises = 0, gap = 0, badgap = 0, badbit = 0, badsync = 0, syncn = 0, extra = 0, n = 0;
    bit prev, a, clr = 0;
    @(negedge clk);
    prev = sclk_out ^ sclk_inv;
    while (rises < 16 && n < 4000) begin
      @(negedge clk); n++; gap++;
      if (clr) begin res_valid = 1'b0; clr = 0; end
      a = sclk_out ^ sclk_inv;
      if (a && !prev) begin
        rises++;
        if (rises > 1 && gap != period) badgap++;
        gap = 0;
        if (sdout !== expw[16 - rises]) badbit++;
        if (sync !== ~sync_low) badsync++;
        if (inject && rises == 5) begin res_data = injw; res_valid = 1'b1; clr = 1; end
      end
      if (rises > 0 && sync !== sync_low) syncn++;
      prev = a;
    end
    chk(rises == 16, req, "R2 active edge count", rises, 16);
    chk(badbit == 0, req, "R2 R9 bit errors", badbit, 0);
    chk(badgap == 0, req, "R5 period errors", badgap, 0);
    chk(badsync == 0, req, "R6 sync level errors", badsync, 0);
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      a = sclk_out ^ sclk_inv;
      if (a && !prev) extra++;
      if (sync !== sync_low) syncn++;
      prev = a;
    end
    chk(extra == 0, req, "R8 extra edge", extra, 0);
    chk(syncn == 16 * period, req, "R8 sync cycles", syncn, 16 * period);
    chk(sync === sync_low && sdout === 1'b0, req, "R8 idle sync/sdout", {sync, sdout}, {sync_low, 1'b0});
    chk(sclk_out === sclk_inv, req, "R8 R7 idle sclk", sclk_out, sclk_inv);
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] w, dbits, cw;
    int d, nr;
    bit prev, a;
    void'($urandom(32'd7));
    do_reset;
    chk(sdout === 1'b0 && sync === 1'b0 && sclk_out === 1'b0, "R1", "reset state",
        {sdout, sync, sclk_out}, 0);
    sclk_inv = 1'b1; sync_low = 1'b1;
    @(negedge clk);
    chk(sync === 1'b1 && sclk_out === 1'b1, "R1", "idle levels inverted R6 R7", {sync, sclk_out}, 3);
    sclk_inv = 1'b0; sync_low = 1'b0;

    send(16'hA5C3);
    run_master(code(16'hA5C3, 1'b1), 2, 0, 0, "R2");

    bin_fmt = 1'b0;
    send(16'h0001);
    run_master(16'h8001, 2, 0, 0, "R9");
    bin_fmt = 1'b1;

    div_code = 2'd3;
    send(16'h3C96);
    run_master(16'h3C96, 16, 0, 0, "R5");

    div_code = 2'd1; conv_busy = 1'b1;
    send(16'h7E11);
    nr = 0;
    @(negedge clk); prev = sclk_out ^ sclk_inv;
    repeat (60) begin
      @(negedge clk); a = sclk_out ^ sclk_inv;
      if ((a && !prev) || sync !== sync_low) nr++;
      prev = a;
    end
    chk(nr == 0, "R3", "activity while busy", nr, 0);
    conv_busy = 1'b0;
    run_master(16'h7E11, 4, 0, 0, "R3");

    read_during = 1'b1; div_code = 2'd3; conv_busy = 1'b1;
    send(16'hC0DE);
    run_master(16'hC0DE, 2, 0, 0, "R4");
    conv_busy = 1'b0; read_during = 1'b0; div_code = 2'd0;

    send(16'h1234);
    run_master(16'h1234, 2, 1, 16'hBEEF, "R12");
    run_master(16'hBEEF, 2, 0, 0, "R12");

    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      d = $urandom_range(0, 3);
      div_code = 2'(d);
      read_during = 1'($urandom_range(0, 1));
      sclk_inv = 1'($urandom_range(0, 1));
      sync_low = 1'($urandom_range(0, 1));
      bin_fmt = 1'($urandom_range(0, 1));
      w = 16'($urandom);
      @(negedge clk);
      send(w);
      run_master(code(w, bin_fmt), per(d, !read_during), 0, 0, "R7 random");
    end

    ext_clk_sel = 1'b1; sclk_inv = 1'b1; sync_low = 1'b1; bin_fmt = 1'b0;
    div_code = 2'd3; read_during = 1'b0; sclk_in = 1'b1;
    do_reset;
    w = 16'h5AF0; cw = code(w, 1'b0); dbits = 16'hC35A;
    send(w);
    repeat (5) @(negedge clk);
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      sdin = (k <= 16) ? dbits[16 - k] : 1'b0;
      sclk_in = ~sclk_inv;
      repeat (6) @(negedge clk);
      if (k <= 16) begin
        chk(sdout === cw[16 - k], "R10", "slave bit", sdout, cw[16 - k]);
        chk(sync === 1'b0, "R6", "slave sync active low", sync, 0);
      end else begin
        chk(sdout === dbits[32 - k], "R11", "chained bit", sdout, dbits[32 - k]);
        chk(sync === 1'b1, "R8", "slave sync after 16", sync, 1);
      end
      sclk_in = sclk_inv;
      repeat (6) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule